// File: doc/BRIEF.md
# Two-Channel PCM Serial Data Engine

This block moves audio samples between parallel FIFO words and a serial data line. Each frame carries two channels in each direction. A frame generator outside the block supplies a one-cycle bit strobe and the index of the current bit within the frame. On every strobe the block drives one transmit bit and samples one receive bit. Transmit words come from a first-word-fall-through FIFO. Completed receive words are pushed into a receive FIFO.

Each direction has its own 32-bit configuration word. For each channel, the word sets an enable, a sample width and a start position, counted in bit clocks from the frame start. Because the start position is free, the same logic covers every frame layout used by the surrounding software: I2S (one-bit delay), left-justified, right-justified (delay equal to slot width minus data width), DSP, and any two slots of a TDM frame. For samples of 16 bits or fewer, a packed mode carries both channels in one FIFO word. Received samples can be sign-extended.

Top module: `pcm_serdes2`

## Requirements
- R1: Each configuration word holds channel 1 in bits 31:16 and channel 2 in bits 15:0. Within a half, the fields are:
  - bit 14: enable (so bit 30 enables channel 1 and bit 14 enables channel 2).
  - bits 13:4: start position.
  - width = bits 3:0 plus 8, plus 16 more when bit 15 is set.
  - Valid widths are 8 to 32.
- R2: A channel's sample is sent MSB first. Its first bit goes out on the strobe whose bit index equals the start position. `sdo` changes only on the clock edge of a strobe and is 0 for bits outside every enabled channel.
- R3: In unpacked mode, each enabled transmit channel pops one FIFO word on the strobe at its start position. The channel sends the low `width` bits of that word.
- R4: In packed mode, a single pop at channel 1's start feeds both channels: channel 1 sends bits 15:0 and channel 2 sends bits 31:16. If channel 1 is disabled, channel 2 pops at its own start and sends bits 31:16.
- R5: If the transmit FIFO is empty when a word is due, no pop occurs and the affected channel(s) send zeros. `tx_underrun` pulses for one cycle, in the cycle after that strobe.
- R6: Where the two channels' bit ranges overlap, the bits belong to channel 1 in both directions. Channel 2 transmits nothing there, and a received channel-2 sample holds 0 at those bit positions.
- R7: In unpacked mode, each enabled receive channel pushes one word in the cycle after its last bit. The sample sits in the low `width` bits, and the bits above it are zero when sign extension is off.
- R8: With `rx_sext` set, the bits above a received sample copy its MSB. This fills 32 bits in unpacked mode and 16 bits per half in packed mode.
- R9: In packed receive mode, one word is pushed after channel 2's last bit, holding channel 1 in bits 15:0 and channel 2 in bits 31:16. A channel that is disabled contributes a zero half, and the push follows the last bit of the enabled channel.
- R10: A disabled channel never pops, never pushes and never drives a 1 on `sdo`.
- R11: While `rst_n` is low at a clock edge, `sdo`, `tx_underrun` and `rx_fifo_push` are 0 from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_en | input | 1 | One-cycle strobe per serial bit |
| bit_idx | input | FRAME_W | Index of the current bit within the frame |
| tx_cfg | input | 32 | Transmit channel layout |
| rx_cfg | input | 32 | Receive channel layout |
| tx_pack | input | 1 | Two 16-bit transmit samples per FIFO word |
| rx_pack | input | 1 | Two 16-bit receive samples per FIFO word |
| rx_sext | input | 1 | Sign-extend received samples |
| tx_fifo_empty | input | 1 | Transmit FIFO has no word |
| tx_fifo_data | input | 32 | Head word of the transmit FIFO |
| tx_fifo_pop | output | 1 | Consume the head word (same cycle) |
| sdo | output | 1 | Serial transmit data |
| tx_underrun | output | 1 | Pulse: a word was due while the FIFO was empty |
| sdi | input | 1 | Serial receive data, sampled on the strobe |
| rx_fifo_push | output | 1 | Receive word valid |
| rx_fifo_data | output | 32 | Receive word |

## Verification
The checks assume the following about the block's inputs:
- Configuration changes only between frames.
- Widths stay within 8 to 32, and at most 16 in packed mode.
- In packed mode channel 1 starts before channel 2.
- Two strobes are never adjacent.
- `tx_fifo_data` is valid whenever `tx_fifo_empty` is low.

The stimulus respects all of these:
- It rewrites the configuration only before bit 0 of a frame.
- It strobes every second cycle.
- It uses widths of 16, 20, 24 and 32 with channel 1 placed earlier in the frame.
- It acts as the transmit FIFO itself, so the head word always matches the empty flag.

// File: rtl/pcm_pkg.sv
// Shared constants, channel descriptor and helpers for the PCM serial engine.
package pcm_pkg;
    localparam int WORD_W = 32;
    localparam int HALF_W = WORD_W / 2;
    localparam int IDX_W  = $clog2(WORD_W);
    localparam int POS_W  = 10;
    localparam int WID_W  = 6;

    typedef struct packed {
        logic             en;
        logic [WID_W-1:0] width;
        logic [POS_W-1:0] pos;
    } chan_cfg_t;

    // Turn one 16-bit configuration half into a channel descriptor.
    function automatic chan_cfg_t decode_half(input logic [15:0] h);
        chan_cfg_t c;
        c.en    = h[14];
        c.pos   = h[13:4];
        c.width = {2'b00, h[3:0]} + 6'd8 + (h[15] ? 6'd16 : 6'd0);
        return c;
    endfunction

    // Fill bits above a sample of width w; half limits the result to 16 bits.
    function automatic logic [WORD_W-1:0] extend(input logic [WORD_W-1:0] v,
                                                 input logic [WID_W-1:0] w,
                                                 input logic sx, input logic half);
        logic [WORD_W-1:0] r;
        logic sign;
        sign = v[IDX_W'(w - 6'd1)];
        for (int i = 0; i < WORD_W; i++) begin
            if (half && i >= HALF_W)
                r[i] = 1'b0;
            else if (i < int'(w))
                r[i] = v[i];
            else
                r[i] = sx & sign;
        end
        return r;
    endfunction
endpackage

// File: rtl/pcm_cfg_decode.sv
// Splits a direction's configuration word into two channel descriptors.
// Index 0 is channel 1 (upper half), index 1 is channel 2 (lower half).
module pcm_cfg_decode
    import pcm_pkg::*;
(
    input  logic [WORD_W-1:0]   cfg_word,
    output chan_cfg_t [1:0]     ch
);
    for (genvar g = 0; g < 2; g++) begin : g_half
        // Decode one half-word into its channel fields.
        assign ch[g] = decode_half(cfg_word[WORD_W-1-HALF_W*g -: HALF_W]);
    end
endmodule

// File: rtl/pcm_chan_window.sv
// Locates the current bit index against one channel's bit range.
// Gives in-window, first-bit flags and the sample bit index (MSB first).
// Assumes width <= WORD_W so the index fits IDX_W bits inside the window.
module pcm_chan_window
    import pcm_pkg::*;
#(
    parameter int FRAME_W = 10
) (
    input  chan_cfg_t          cfg,
    input  logic [FRAME_W-1:0] bit_idx,
    output logic               in_win,
    output logic               first,
    output logic [IDX_W-1:0]   msb
);
    localparam int IW = ((FRAME_W > POS_W) ? FRAME_W : POS_W) + 1;

    logic [IW-1:0] b_x, p_x, k;

    // Offset of the bit index from the channel start and range test.
    always_comb begin
        b_x    = IW'(bit_idx);
        p_x    = IW'(cfg.pos);
        k      = b_x - p_x;
        in_win = cfg.en && (b_x >= p_x) && (k < IW'(cfg.width));
        first  = cfg.en && (b_x == p_x);
        msb    = IDX_W'(cfg.width - 6'd1 - k[5:0]);
    end
endmodule

// File: rtl/pcm_tx_path.sv
// Transmit serializer: fetches words from a fall-through FIFO at channel
// starts and drives one bit per strobe. Channel 1 owns overlapping bits.
// Assumes strobes are never adjacent and fifo_data is valid when not empty.
module pcm_tx_path
    import pcm_pkg::*;
#(
    parameter int FRAME_W = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bit_en,
    input  logic [FRAME_W-1:0] bit_idx,
    input  chan_cfg_t [1:0]    cfg,
    input  logic               pack,
    input  logic               fifo_empty,
    input  logic [WORD_W-1:0]  fifo_data,
    output logic               fifo_pop,
    output logic               sdo,
    output logic               underrun
);
    logic [1:0]        in_w, first_w;
    logic [IDX_W-1:0]  msb_w [2];
    logic [WORD_W-1:0] hold1_q, hold2_q, cur1, cur2, lo, hi;
    logic              fetch1, fetch2, bit_d, under_d;

    for (genvar g = 0; g < 2; g++) begin : g_win
        pcm_chan_window #(.FRAME_W(FRAME_W)) i_win (
            .cfg     (cfg[g]),
            .bit_idx (bit_idx),
            .in_win  (in_w[g]),
            .first   (first_w[g]),
            .msb     (msb_w[g])
        );
    end

    // Pick fetch points, split the FIFO word and select the outgoing bit.
    always_comb begin
        fetch1 = bit_en && first_w[0];
        fetch2 = bit_en && first_w[1] && !(pack && cfg[0].en);
        lo = pack ? {{HALF_W{1'b0}}, fifo_data[HALF_W-1:0]} : fifo_data;
        hi = pack ? {{HALF_W{1'b0}}, fifo_data[WORD_W-1:HALF_W]} : fifo_data;
        if (fifo_empty) begin
            lo = '0;
            hi = '0;
        end
        cur1 = fetch1 ? lo : hold1_q;
        cur2 = (fetch2 || (fetch1 && pack)) ? hi : hold2_q;
        fifo_pop = (fetch1 || fetch2) && !fifo_empty;
        under_d  = (fetch1 || fetch2) && fifo_empty;
        if (in_w[0])      bit_d = cur1[msb_w[0]];
        else if (in_w[1]) bit_d = cur2[msb_w[1]];
        else              bit_d = 1'b0;
    end

    // Register the serial bit, the held samples and the underrun pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sdo      <= 1'b0;
            underrun <= 1'b0;
            hold1_q  <= '0;
            hold2_q  <= '0;
        end else begin
            underrun <= under_d;
            if (bit_en) begin
                sdo     <= bit_d;
                hold1_q <= cur1;
                hold2_q <= cur2;
            end
        end
    end
endmodule

// File: rtl/pcm_rx_path.sv
// Receive deserializer: places each sampled bit at its MSB-first position,
// then extends and pushes finished samples, packed or one per word.
// Assumes in packed mode that channel 1 ends before channel 2.
module pcm_rx_path
    import pcm_pkg::*;
#(
    parameter int FRAME_W = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bit_en,
    input  logic [FRAME_W-1:0] bit_idx,
    input  chan_cfg_t [1:0]    cfg,
    input  logic               pack,
    input  logic               sext,
    input  logic               sdi,
    output logic               push,
    output logic [WORD_W-1:0]  data
);
    logic [1:0]        in_w, first_w;
    logic [IDX_W-1:0]  msb_w [2];
    logic [WORD_W-1:0] acc1_q, acc2_q, acc1_n, acc2_n, s1, s2, data_d;
    logic [HALF_W-1:0] pend_q, pend_d;
    logic              done1, done2, push_d;

    for (genvar g = 0; g < 2; g++) begin : g_win
        pcm_chan_window #(.FRAME_W(FRAME_W)) i_win (
            .cfg     (cfg[g]),
            .bit_idx (bit_idx),
            .in_win  (in_w[g]),
            .first   (first_w[g]),
            .msb     (msb_w[g])
        );
    end

    // Accumulate bits, detect completed samples and form the push word.
    always_comb begin
        acc1_n = (bit_en && first_w[0]) ? '0 : acc1_q;
        if (bit_en && in_w[0]) acc1_n[msb_w[0]] = sdi;
        acc2_n = (bit_en && first_w[1]) ? '0 : acc2_q;
        if (bit_en && in_w[1] && !in_w[0]) acc2_n[msb_w[1]] = sdi;
        done1  = bit_en && in_w[0] && (msb_w[0] == '0);
        done2  = bit_en && in_w[1] && (msb_w[1] == '0);
        s1     = extend(acc1_n, cfg[0].width, sext, pack);
        s2     = extend(acc2_n, cfg[1].width, sext, pack);
        push_d = 1'b0;
        data_d = '0;
        pend_d = pend_q;
        if (pack) begin
            if (done1 && cfg[1].en) pend_d = s1[HALF_W-1:0];
            if (done2) begin
                push_d = 1'b1;
                data_d = {s2[HALF_W-1:0], cfg[0].en ? pend_q : {HALF_W{1'b0}}};
            end else if (done1 && !cfg[1].en) begin
                push_d = 1'b1;
                data_d = {{HALF_W{1'b0}}, s1[HALF_W-1:0]};
            end
        end else if (done1) begin
            push_d = 1'b1;
            data_d = s1;
        end else if (done2) begin
            push_d = 1'b1;
            data_d = s2;
        end
    end

    // Hold accumulators and the pending half; register the push.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc1_q <= '0;
            acc2_q <= '0;
            pend_q <= '0;
            push   <= 1'b0;
            data   <= '0;
        end else begin
            acc1_q <= acc1_n;
            acc2_q <= acc2_n;
            pend_q <= pend_d;
            push   <= push_d;
            if (push_d) data <= data_d;
        end
    end
endmodule

// File: rtl/pcm_serdes2.sv
// Top of the two-channel PCM serial engine: decodes both direction
// configurations and runs independent transmit and receive paths off
// the shared bit strobe and bit index from the frame generator.
module pcm_serdes2
    import pcm_pkg::*;
#(
    parameter int FRAME_W = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bit_en,
    input  logic [FRAME_W-1:0] bit_idx,
    input  logic [31:0]        tx_cfg,
    input  logic [31:0]        rx_cfg,
    input  logic               tx_pack,
    input  logic               rx_pack,
    input  logic               rx_sext,
    input  logic               tx_fifo_empty,
    input  logic [31:0]        tx_fifo_data,
    output logic               tx_fifo_pop,
    output logic               sdo,
    output logic               tx_underrun,
    input  logic               sdi,
    output logic               rx_fifo_push,
    output logic [31:0]        rx_fifo_data
);
    chan_cfg_t [1:0] tx_ch, rx_ch;

    pcm_cfg_decode i_tx_dec (.cfg_word(tx_cfg), .ch(tx_ch));
    pcm_cfg_decode i_rx_dec (.cfg_word(rx_cfg), .ch(rx_ch));

    pcm_tx_path #(.FRAME_W(FRAME_W)) i_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_en     (bit_en),
        .bit_idx    (bit_idx),
        .cfg        (tx_ch),
        .pack       (tx_pack),
        .fifo_empty (tx_fifo_empty),
        .fifo_data  (tx_fifo_data),
        .fifo_pop   (tx_fifo_pop),
        .sdo        (sdo),
        .underrun   (tx_underrun)
    );

    pcm_rx_path #(.FRAME_W(FRAME_W)) i_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_en  (bit_en),
        .bit_idx (bit_idx),
        .cfg     (rx_ch),
        .pack    (rx_pack),
        .sext    (rx_sext),
        .sdi     (sdi),
        .push    (rx_fifo_push),
        .data    (rx_fifo_data)
    );
endmodule

// File: rtl/pcm_serdes2_chk.sv
// Property checker for pcm_serdes2, attached by bind.
// Assumes strobes never fall on adjacent cycles.
module pcm_serdes2_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        bit_en,
    input logic [31:0] tx_cfg,
    input logic [31:0] rx_cfg,
    input logic        tx_fifo_empty,
    input logic        tx_fifo_pop,
    input logic        sdo,
    input logic        tx_underrun,
    input logic        rx_fifo_push
);
    // R2: serial output only moves on a strobe edge
    p_sdo_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(sdo));

    // R5: an underrun pulse follows a strobe that met an empty FIFO
    p_underrun_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_underrun |-> $past(bit_en && tx_fifo_empty));

    // R7: pushes only follow a strobe
    p_push_on_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_fifo_push |-> $past(bit_en));

    // R10: with both transmit channels off, nothing is fetched or sent
    p_quiet_tx_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && !tx_cfg[30] && !tx_cfg[14]) |=> (!sdo && !tx_underrun));

    // R10: no pop while both transmit channels are off
    p_no_pop_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_cfg[30] && !tx_cfg[14]) |-> !tx_fifo_pop);

    // R10: with both receive channels off, nothing is pushed
    p_quiet_rx_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && !rx_cfg[30] && !rx_cfg[14]) |=> !rx_fifo_push);

    // R11: reset clears the registered outputs
    p_reset_r11: assert property (@(posedge clk)
        !rst_n |=> (!sdo && !tx_underrun && !rx_fifo_push));
endmodule

bind pcm_serdes2 pcm_serdes2_chk i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bit_en        (bit_en),
    .tx_cfg        (tx_cfg),
    .rx_cfg        (rx_cfg),
    .tx_fifo_empty (tx_fifo_empty),
    .tx_fifo_pop   (tx_fifo_pop),
    .sdo           (sdo),
    .tx_underrun   (tx_underrun),
    .rx_fifo_push  (rx_fifo_push)
);

// File: tb/test_pcm_serdes2.sv
// Bench: behavioural frame model (queues, integers) compared every clock.
module test_pcm_serdes2;
    localparam int FRAME_W = 10;
    localparam int FRAME   = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_en = 1'b0;
    logic [FRAME_W-1:0] bit_idx = '0;
    logic [31:0] tx_cfg = '0, rx_cfg = '0;
    logic        tx_pack = 1'b0, rx_pack = 1'b0, rx_sext = 1'b0;
    logic        tx_fifo_empty = 1'b1;
    logic [31:0] tx_fifo_data = '0;
    logic        tx_fifo_pop, sdo, tx_underrun, rx_fifo_push;
    logic        sdi = 1'b0;
    logic [31:0] rx_fifo_data;

    always #4 clk = ~clk;

    pcm_serdes2 #(.FRAME_W(FRAME_W)) i_pcm_serdes2 (.*);

    int checks = 0, errors = 0;
    bit done = 0;
    string tag = "R11";
    logic [31:0] txq[$];
    logic [31:0] rxexp[$];
    bit txexp[FRAME];
    bit rxbits[FRAME];
    bit exp_sdo = 0, pend_sdo = 0, last_tick = 0;
    int exp_pops, exp_under, got_pops, got_under;

    task automatic check(input bit ok, input string t, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", t, what, act, exp);
        end
    endtask

    function automatic logic [15:0] mk(input bit e, input int w, input int p);
        bit x = (w >= 24);
        int nib = x ? w - 24 : w - 8;
        return {x, e, 10'(p), 4'(nib)};
    endfunction

    function automatic void dec(input logic [15:0] h, output bit e, output int w, output int p);
        e = h[14];
        w = int'(h[3:0]) + 8 + (h[15] ? 16 : 0);
        p = int'(h[13:4]);
    endfunction

    function automatic logic [31:0] ext(input logic [31:0] v, input int w, input bit sx, input bit half);
        logic [31:0] r = '0;
        int lim = half ? 16 : 32;
        for (int i = 0; i < lim; i++) r[i] = (i < w) ? v[i] : (sx & v[w-1]);
        return r;
    endfunction

    // Sample outputs of the previous cycle and play the transmit FIFO.
    task automatic observe();
        logic [31:0] e;
        if (last_tick) exp_sdo = pend_sdo;
        check(sdo == exp_sdo, tag, "sdo", {31'b0, sdo}, {31'b0, exp_sdo});
        if (tx_fifo_pop) begin
            got_pops++;
            if (txq.size() > 0) void'(txq.pop_front());
        end
        if (tx_underrun) got_under++;
        if (rx_fifo_push) begin
            if (rxexp.size() == 0) check(0, tag, "unexpected push", rx_fifo_data, 32'h0);
            else begin
                e = rxexp.pop_front();
                check(rx_fifo_data == e, tag, "rx word", rx_fifo_data, e);
            end
        end
    endtask

    task automatic step(input bit en, input int b);
        @(negedge clk);
        observe();
        bit_en = en;
        bit_idx = FRAME_W'(b);
        sdi = rxbits[b];
        tx_fifo_empty = (txq.size() == 0);
        tx_fifo_data = tx_fifo_empty ? 32'h0 : txq[0];
        last_tick = en;
        pend_sdo = txexp[b];
    endtask

    // Predict one frame from the requirements.
    task automatic build();
        bit e1, e2, in1, in2;
        int w1, p1, w2, p2, used;
        logic [31:0] d, word1, word2, s1, s2;
        exp_pops = 0; exp_under = 0; used = 0;
        word1 = '0; word2 = '0;
        dec(tx_cfg[31:16], e1, w1, p1);
        dec(tx_cfg[15:0], e2, w2, p2);
        if (e1) begin
            if (used < txq.size()) begin d = txq[used]; used++; exp_pops++; end
            else begin d = '0; exp_under++; end
            word1 = tx_pack ? {16'h0, d[15:0]} : d;
            if (tx_pack) word2 = {16'h0, d[31:16]};
        end
        if (e2 && !(tx_pack && e1)) begin
            if (used < txq.size()) begin d = txq[used]; used++; exp_pops++; end
            else begin d = '0; exp_under++; end
            word2 = tx_pack ? {16'h0, d[31:16]} : d;
        end
        for (int b = 0; b < FRAME; b++) begin
            in1 = e1 && b >= p1 && b < p1 + w1;
            in2 = e2 && b >= p2 && b < p2 + w2;
            txexp[b] = in1 ? word1[w1-1-(b-p1)] : in2 ? word2[w2-1-(b-p2)] : 1'b0;
        end
        dec(rx_cfg[31:16], e1, w1, p1);
        dec(rx_cfg[15:0], e2, w2, p2);
        s1 = '0; s2 = '0;
        for (int b = 0; b < FRAME; b++) begin
            rxbits[b] = 1'($urandom);
            in1 = e1 && b >= p1 && b < p1 + w1;
            in2 = e2 && b >= p2 && b < p2 + w2;
            if (in1) s1[w1-1-(b-p1)] = rxbits[b];
            else if (in2) s2[w2-1-(b-p2)] = rxbits[b];
        end
        s1 = ext(s1, w1, rx_sext, rx_pack);
        s2 = ext(s2, w2, rx_sext, rx_pack);
        if (rx_pack) begin
            if (e1 && e2) rxexp.push_back({s2[15:0], s1[15:0]});
            else if (e1)  rxexp.push_back({16'h0, s1[15:0]});
            else if (e2)  rxexp.push_back({s2[15:0], 16'h0});
        end else begin
            if (e1) rxexp.push_back(s1);
            if (e2) rxexp.push_back(s2);
        end
    endtask

    task automatic frames(input string t, input int n, input int words);
        tag = t;
        for (int f = 0; f < n; f++) begin
            for (int i = 0; i < words; i++) txq.push_back($urandom);
            build();
            got_pops = 0; got_under = 0;
            for (int b = 0; b < FRAME; b++) begin
                step(1, b);
                step(0, b);
            end
            check(got_pops == exp_pops, t, "pop count", got_pops, exp_pops);
            check(got_under == exp_under, t, "underrun count", got_under, exp_under);
            check(rxexp.size() == 0, t, "missing push", rxexp.size(), 0);
            rxexp.delete();
        end
    endtask

    task automatic setup(input logic [15:0] c1, input logic [15:0] c2,
                         input bit tp, input bit rp, input bit sx);
        tx_cfg = {c1, c2}; rx_cfg = {c1, c2};
        tx_pack = tp; rx_pack = rp; rx_sext = sx;
        txq.delete();
    endtask

    initial begin
        repeat (4) @(negedge clk);
        check(sdo == 0 && tx_underrun == 0 && rx_fifo_push == 0 && tx_fifo_pop == 0,
              "R11", "reset outputs", {sdo, tx_underrun, rx_fifo_push, tx_fifo_pop}, 0);
        rst_n = 1'b1;
        // I2S layout, 16-bit samples, 1-bit delay, odd slot at half frame
        setup(mk(1, 16, 1), mk(1, 16, 33), 0, 0, 0);
        frames("R1/R2/R3/R7", 3, 2);
        // packed both directions, with sign extension per half
        setup(mk(1, 16, 1), mk(1, 16, 33), 1, 1, 1);
        frames("R4/R9/R8", 3, 1);
        // left-justified 24-bit with extension bit
        setup(mk(1, 24, 0), mk(1, 24, 32), 0, 0, 1);
        frames("R1/R8", 3, 2);
        // full 32-bit DSP words
        setup(mk(1, 32, 0), mk(1, 32, 32), 0, 0, 1);
        frames("R1/R2", 2, 2);
        // right-justified 20 in 32-bit slots, signed then unsigned
        setup(mk(1, 20, 12), mk(1, 20, 44), 0, 0, 1);
        frames("R8", 2, 2);
        rx_sext = 0;
        frames("R7", 2, 2);
        // TDM slots 1 and 3 of four
        setup(mk(1, 16, 16), mk(1, 16, 48), 0, 0, 0);
        frames("R2/R3", 2, 2);
        // starved FIFO: one word for two channels, then none when packed
        setup(mk(1, 16, 1), mk(1, 16, 33), 0, 0, 0);
        frames("R5", 2, 1);
        setup(mk(1, 16, 1), mk(1, 16, 33), 1, 1, 0);
        frames("R5", 2, 0);
        // overlapping ranges, channel 1 wins
        setup(mk(1, 24, 0), mk(1, 16, 16), 0, 0, 0);
        frames("R6", 3, 2);
        // channel 2 off, then channel 1 off packed, then both off
        setup(mk(1, 16, 1), mk(0, 16, 33), 0, 0, 0);
        frames("R10", 2, 2);
        setup(mk(0, 16, 1), mk(1, 16, 33), 1, 1, 1);
        frames("R10/R4/R9", 2, 1);
        setup(mk(0, 16, 1), mk(0, 16, 33), 0, 0, 0);
        frames("R10", 1, 2);
        repeat (4) step(0, 0);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog run did not finish actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule